// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of an I2C master. Software writes one byte (data, a 7-bit address followed by the direction bit, or either half of a 10-bit address) into the transmit port. The block then shifts the byte out on SDA, most significant bit first, and generates SCL from a reload counter that runs only while a transfer is in flight. After the eighth bit it lets go of SDA so that the slave can drive the acknowledge. On the ninth falling edge of SCL it samples that acknowledge, raises an interrupt flag and parks the bus with SCL held low.

Both bus lines are open drain. Each one has a registered drive-low enable, and the SDA line is read back through a sampled input. A write that arrives while a byte is still going out is refused and recorded in a sticky collision flag. Generating start and stop conditions, receiving, arbitration and clock stretching are handled by other logic.

Top module: `i2c_byte_tx`

## Requirements
- R1: A write accepted while idle sets `buf_full` on the next clock. On that same edge the block drives SCL low and puts the byte's bit 7 on SDA (`sda_drive_low` = inverse of the bit).
- R2: The bits leave most significant bit first, one per SCL clock. SDA changes only on an SCL falling edge and stays unchanged while SCL is released.
- R3: With a reload value N, every SCL low phase after the first and every SCL high phase of a transfer lasts exactly N+1 clocks.
- R4: On the falling edge of the eighth SCL clock, `buf_full` clears and SDA is released.
- R5: On the falling edge of the ninth SCL clock, the SDA line is sampled into `ack_stat`: 0 when the slave pulled it low (acknowledge), 1 when it stayed high.
- R6: After the ninth clock, `irq` is set, SCL stays driven low and SDA stays released. SCL does not toggle again until the next accepted write.
- R7: A write made from the accepting edge up to and including the ninth SCL falling edge sets `wcol`. It does not start a transfer, and it does not alter the bits of the byte in flight.
- R8: `wcol` and `irq` stay set until their clear inputs are pulsed. If a set and a clear happen in the same cycle, the set wins.
- R9: Reset, which is synchronous, clears `buf_full`, `wcol`, `ack_stat` and `irq`, stops the clock generator and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | RLD_W | Half-period reload value N (N+1 clocks per SCL half period) |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| wcol_clr | input | 1 | Clears the write-collision flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| sda_in | input | 1 | Sampled state of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| buf_full | output | 1 | Byte loaded and not yet fully shifted |
| wcol | output | 1 | Sticky write-collision flag |
| ack_stat | output | 1 | Last sampled acknowledge (1 = not acknowledged) |
| irq | output | 1 | Sticky transfer-complete flag |

## Verification
The assertions take for granted that `sda_in` is already synchronous to `clk` and that `reload` does not change while a byte is in flight. The bench keeps to both: it alters the reload only between transfers, and it models the slave as a registered pull on the SDA line that is updated between clock edges. The slave begins pulling only after the eighth SCL fall is seen and lets go after the ninth, so SDA never moves while SCL is high.

// File: rtl/i2ctx_pkg.sv
package i2ctx_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/i2ctx_baud.sv
module i2ctx_baud #(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [RLD_W-1:0] reload,
  output logic             tick
);
  logic [RLD_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= reload;
    end else if (!run || tick) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: with a nonzero reload, two rollovers are never back to back
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && run && reload != '0 && $stable(reload)) |=> !tick);
endmodule

// File: rtl/i2ctx_shift.sv
module i2ctx_shift
  import i2ctx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              tick,
  output logic              busy,
  output logic              scl_dl,
  output logic              sda_dl,
  output logic              data_done,
  output logic              ack_evt
);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] ACK_SLOT  = IDX_W'(DATA_W);

  scl_phase_e        phase;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sh;
  logic              fall_evt;

  assign fall_evt  = busy && tick && (phase == PH_HIGH);
  assign data_done = fall_evt && (idx == LAST_DATA);
  assign ack_evt   = fall_evt && (idx == ACK_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      phase  <= PH_LOW;
      idx    <= '0;
      sh     <= '0;
      scl_dl <= 1'b0;
      sda_dl <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      phase  <= PH_LOW;
      idx    <= '0;
      sh     <= din;
      scl_dl <= 1'b1;
      sda_dl <= ~din[DATA_W-1];
    end else if (busy && tick) begin
      if (phase == PH_LOW) begin
        phase  <= PH_HIGH;
        scl_dl <= 1'b0;
      end else begin
        phase  <= PH_LOW;
        scl_dl <= 1'b1;
        if (idx == ACK_SLOT) begin
          busy   <= 1'b0;
          sda_dl <= 1'b0;
        end else if (idx == LAST_DATA) begin
          idx    <= idx + 1'b1;
          sda_dl <= 1'b0;
        end else begin
          idx    <= idx + 1'b1;
          sh     <= sh << 1;
          sda_dl <= ~sh[DATA_W-2];
        end
      end
    end
  end

  // R2: SDA holds while SCL stays released
  a_r2_sda_stable_high: assert property (@(posedge clk) disable iff (rst)
    (!scl_dl && !$past(scl_dl)) |-> $stable(sda_dl));
  // R6: end of a transfer leaves SCL held low and SDA released
  a_r6_parked: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (scl_dl && !sda_dl));
  // R6: no SCL activity while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(scl_dl));
endmodule

// File: rtl/i2ctx_flags.sv
module i2ctx_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic busy,
  input  logic start,
  input  logic data_done,
  input  logic ack_evt,
  input  logic sda_in,
  input  logic wcol_clr,
  input  logic irq_clr,
  output logic buf_full,
  output logic wcol,
  output logic ack_stat,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      wcol     <= 1'b0;
      ack_stat <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (start)          buf_full <= 1'b1;
      else if (data_done) buf_full <= 1'b0;

      if (wr_en && busy)  wcol <= 1'b1;
      else if (wcol_clr)  wcol <= 1'b0;

      if (ack_evt)        irq <= 1'b1;
      else if (irq_clr)   irq <= 1'b0;

      if (ack_evt)        ack_stat <= sda_in;
    end
  end

  // R4: the buffer never reads full once the transfer is over
  a_r4_bf_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !buf_full);
  // R7: a write during a transfer raises the collision flag
  a_r7_wcol_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> wcol);
  // R8: the collision flag only drops on a clear
  a_r8_wcol_sticky: assert property (@(posedge clk) disable iff (rst)
    (wcol && !wcol_clr) |=> wcol);
  // R6: completion raises the interrupt flag
  a_r6_irq_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);
endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
  parameter int DATA_W = 8,
  parameter int RLD_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RLD_W-1:0]  reload,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wcol_clr,
  input  logic              irq_clr,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              buf_full,
  output logic              wcol,
  output logic              ack_stat,
  output logic              irq
);
  logic busy, tick, start, data_done, ack_evt;

  assign start = wr_en && !busy;

  i2ctx_baud #(.RLD_W(RLD_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .reload (reload),
    .tick   (tick)
  );

  i2ctx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .din       (wr_data),
    .tick      (tick),
    .busy      (busy),
    .scl_dl    (scl_drive_low),
    .sda_dl    (sda_drive_low),
    .data_done (data_done),
    .ack_evt   (ack_evt)
  );

  i2ctx_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .busy      (busy),
    .start     (start),
    .data_done (data_done),
    .ack_evt   (ack_evt),
    .sda_in    (sda_in),
    .wcol_clr  (wcol_clr),
    .irq_clr   (irq_clr),
    .buf_full  (buf_full),
    .wcol      (wcol),
    .ack_stat  (ack_stat),
    .irq       (irq)
  );
endmodule

// File: tb/test_i2c_byte_tx.sv
module test_i2c_byte_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reload = 8'd3;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wcol_clr = 1'b0;
  logic       irq_clr = 1'b0;
  logic       sda_in;
  logic       scl_dl, sda_dl, buf_full, wcol, ack_stat, irq;
  logic       slave_pull = 1'b0;
  logic       scl_line;

  assign scl_line = !scl_dl;
  assign sda_in   = !(sda_dl || slave_pull);

  always #5 clk = ~clk;

  i2c_byte_tx i_i2c_byte_tx (
    .clk(clk), .rst(rst), .reload(reload), .wr_en(wr_en), .wr_data(wr_data),
    .wcol_clr(wcol_clr), .irq_clr(irq_clr), .sda_in(sda_in),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .buf_full(buf_full),
    .wcol(wcol), .ack_stat(ack_stat), .irq(irq)
  );

  typedef struct packed { logic [7:0] d; logic nack; } exp_t;
  exp_t exp_q[$];
  int nchk = 0, nfail = 0;
  int done_cnt = 0, rise_total = 0;

  task automatic chk(input string req, input int act, input int expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: reconstructs bytes from the bus and models the slave
  int run_len = 0, nrise = 0;
  logic prev_scl = 1'b1, hold_sda = 1'b1;
  logic [7:0] cap = 8'h00;
  always @(negedge clk) begin
    if (rst) begin
      prev_scl = 1'b1; nrise = 0; run_len = 0; slave_pull = 1'b0;
    end else begin
      run_len++;
      if (scl_line && !prev_scl) begin
        if (nrise > 0) chk("R3 low phase", run_len, int'(reload) + 1);
        if (nrise < 8) cap = {cap[6:0], sda_in};
        hold_sda = sda_in;
        nrise++; rise_total++; run_len = 0;
      end else if (!scl_line && prev_scl) begin
        if (nrise > 0) chk("R3 high phase", run_len, int'(reload) + 1);
        if (nrise == 8) begin
          chk("R4 buf_full at 8th fall", buf_full, 0);
          chk("R4 sda released at 8th fall", sda_dl, 0);
          if (exp_q.size() > 0) slave_pull = !exp_q[0].nack;
        end else if (nrise == 9) begin
          exp_t e;
          slave_pull = 1'b0;
          if (exp_q.size() == 0) chk("R2 unexpected byte", 1, 0);
          else begin
            e = exp_q.pop_front();
            chk("R2 byte msb first", cap, e.d);
            chk("R5 ack_stat", ack_stat, e.nack);
          end
          chk("R6 irq set", irq, 1);
          chk("R6 scl held low", scl_dl, 1);
          chk("R6 sda released", sda_dl, 0);
          nrise = 0; done_cnt++;
        end
        run_len = 0;
      end else if (scl_line && nrise > 0 && sda_in !== hold_sda) begin
        chk("R2 sda stable while scl high", sda_in, hold_sda);
      end
      prev_scl = scl_line;
    end
  end

  task automatic send(input logic [7:0] d, input logic nack);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    exp_q.push_back({d, nack});
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 buf_full", buf_full, 1);
    chk("R1 scl low", scl_dl, 1);
    chk("R1 msb on sda", sda_dl, !d[7]);
  endtask

  task automatic collide(input logic [7:0] d, input logic clr);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wcol_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; wcol_clr = 1'b0;
    chk("R7 wcol on busy write", wcol, 1);
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); irq_clr = 1'b1; wcol_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; wcol_clr = 1'b0;
    chk("R8 irq cleared", irq, 0);
    chk("R8 wcol cleared", wcol, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    int rs;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 scl released", scl_dl, 0);
    chk("R9 sda released", sda_dl, 0);
    chk("R9 flags clear", {buf_full, wcol, ack_stat, irq}, 0);

    reload = 8'd3;
    send(8'hA5, 1'b0);
    wait_done(1);
    rs = rise_total;
    repeat (40) @(negedge clk);
    chk("R6 no toggling while parked", rise_total, rs);
    chk("R6 scl still held", scl_dl, 1);
    chk("R8 irq held", irq, 1);
    clear_flags();

    reload = 8'd0;
    send(8'h3C, 1'b1);
    wait_done(2);
    clear_flags();

    reload = 8'd7;
    send(8'h81, 1'b0);
    repeat (20) @(negedge clk);
    collide(8'hFF, 1'b0);
    chk("R7 buf_full kept", buf_full, 1);
    wait_done(3);
    chk("R8 wcol held after transfer", wcol, 1);
    clear_flags();

    reload = 8'd2;
    send(8'h00, 1'b1);
    repeat (6) @(negedge clk);
    collide(8'h55, 1'b1);   // R8 set beats simultaneous clear
    while (buf_full) @(negedge clk);
    clear_flags();
    collide(8'hC3, 1'b0);   // R7 write in ack slot
    wait_done(4);
    rs = rise_total;
    repeat (30) @(negedge clk);
    chk("R7 rejected write starts nothing", rise_total, rs);
    chk("R7 queue drained", exp_q.size(), 0);
    clear_flags();

    reload = 8'd1;
    send(8'hFF, 1'b0);
    wait_done(5);
    send(8'h6E, 1'b1);
    wait_done(6);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule